// File: doc/BRIEF.md
# Windowed Address Partition Translator

This block turns a host address, drawn from a fixed virtual space, into a device-side physical address. The virtual space holds four partitions in a fixed order, with no gaps between them. The first is a memory window. The second is a register window. The third is a second memory window. The fourth runs from the end of the third up to the top of the virtual space.

Software gives each partition a physical start and, for the first three, a length. Changing a length moves the virtual boundaries of every partition after it. Changing a start only redirects that window. This lets the device move its memory regions between operating stages while host software keeps one fixed address map.

Each request is looked up against the current configuration and answered one clock later. The answer is either a translated address together with the partition number, or a miss flag. A miss carries no access.

Top module: `addr_window_xlat`

## Requirements
- R1: After reset every start and length is zero and the last partition is disabled, so every request misses; while reset is held, `out_valid` and `out_miss` are 0.
- R2: A request with virtual address v below length0 answers with `out_part`=0 and `out_addr` = start0 + v.
- R3: A request with length0 <= v < length0+length1 answers with `out_part`=1 and `out_addr` = start1 + (v - length0).
- R4: A request with b2 <= v < b2+length2, where b2 = length0+length1, answers with `out_part`=2 and `out_addr` = start2 + (v - b2).
- R5: Once start3 has been written, a request with v >= b3 (b3 = length0+length1+length2) answers with `out_part`=3 and `out_addr` = start3 + (v - b3), up to the top virtual address.
- R6: A request that falls in no partition answers with `out_miss`=1, `out_valid`=0, `out_addr`=0 and `out_part`=0.
- R7: Every request is answered exactly one clock after it is sampled, by either `out_valid` or `out_miss`. In a cycle after no request, both are 0.
- R8: Configuration select encoding: 0 start0, 1 length0, 2 start1, 3 length1, 4 start2, 5 length2, 6 start3. Select 7 changes nothing.
- R9: The sums that form physical addresses wrap modulo 2^AW. The virtual boundaries are computed without wrap, so a boundary above the top of the virtual space leaves the later partitions unreachable.
- R10: A partition of length zero never matches.
- R11: A configuration write applies to requests sampled in the following cycle and later. A request sampled in the same cycle as the write uses the previous configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register selector (see R8) |
| cfg_data | input | AW | Value to write |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | AW | Virtual address |
| out_valid | output | 1 | Translated access issued |
| out_miss | output | 1 | Request fell outside every partition |
| out_part | output | 2 | Matching partition number |
| out_addr | output | AW | Physical address |

## Verification
The first pattern sets window lengths by hand and probes both sides of every boundary: the first and last address of each partition, and the address just past each one. This separates off-by-one errors in the compare logic from errors in the offset subtraction. A second group of cases covers zero-length windows, a physical start near the top so that the sum wraps, the reserved select, and a write issued in the same cycle as a request; each exposes a separate corner of the configuration path. Random configurations, paired with addresses drawn near the computed boundaries, then check that the running-sum placement agrees with the bench model across many layouts.

// File: rtl/addr_window_xlat.sv
module addr_window_xlat #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_valid,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_data,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          out_valid,
  output logic          out_miss,
  output logic [1:0]    out_part,
  output logic [AW-1:0] out_addr
);
  localparam int SW = AW + 2;

  logic [AW-1:0] st0, st1, st2, st3;
  logic [AW-1:0] sz0, sz1, sz2;
  logic          p3_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st0 <= '0; st1 <= '0; st2 <= '0; st3 <= '0;
      sz0 <= '0; sz1 <= '0; sz2 <= '0;
      p3_en <= 1'b0;
    end else if (cfg_valid) begin
      case (cfg_sel)
        3'd0: st0 <= cfg_data;
        3'd1: sz0 <= cfg_data;
        3'd2: st1 <= cfg_data;
        3'd3: sz1 <= cfg_data;
        3'd4: st2 <= cfg_data;
        3'd5: sz2 <= cfg_data;
        3'd6: begin st3 <= cfg_data; p3_en <= 1'b1; end
        default: ;
      endcase
    end
  end

  logic [SW-1:0] b1, b2, b3, e0, e1, e2, v;
  assign v  = SW'(req_addr);
  assign b1 = SW'(sz0);
  assign b2 = b1 + SW'(sz1);
  assign b3 = b2 + SW'(sz2);
  assign e0 = b1;
  assign e1 = b2;
  assign e2 = b3;

  logic h0, h1, h2, h3;
  assign h0 = v < e0;
  assign h1 = (v >= b1) && (v < e1);
  assign h2 = (v >= b2) && (v < e2);
  assign h3 = p3_en && (v >= b3);

  logic [AW-1:0] p0, p1, p2, p3;
  assign p0 = st0 + req_addr;
  assign p1 = st1 + (req_addr - b1[AW-1:0]);
  assign p2 = st2 + (req_addr - b2[AW-1:0]);
  assign p3 = st3 + (req_addr - b3[AW-1:0]);

  logic          hit;
  logic [1:0]    part_n;
  logic [AW-1:0] addr_n;
  always_comb begin
    hit = 1'b1; part_n = 2'd0; addr_n = '0;
    if (h0)      begin part_n = 2'd0; addr_n = p0; end
    else if (h1) begin part_n = 2'd1; addr_n = p1; end
    else if (h2) begin part_n = 2'd2; addr_n = p2; end
    else if (h3) begin part_n = 2'd3; addr_n = p3; end
    else hit = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_miss  <= 1'b0;
      out_part  <= '0;
      out_addr  <= '0;
    end else begin
      out_valid <= req_valid && hit;
      out_miss  <= req_valid && !hit;
      out_part  <= (req_valid && hit) ? part_n : 2'd0;
      out_addr  <= (req_valid && hit) ? addr_n : '0;
    end
  end
endmodule

module addr_window_xlat_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_valid,
  input logic [2:0]    cfg_sel,
  input logic          req_valid,
  input logic [AW-1:0] req_addr,
  input logic          out_valid,
  input logic          out_miss,
  input logic [1:0]    out_part,
  input logic [AW-1:0] out_addr,
  input logic [AW-1:0] st0,
  input logic [AW-1:0] sz0,
  input logic [AW-1:0] st3,
  input logic          p3_en
);
  logic [AW-1:0] sum0;
  assign sum0 = st0 + req_addr;

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (!out_valid && !out_miss)); // R1
  AST_PART0_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr < sz0) |=> (out_valid && out_part == 2'd0 && out_addr == $past(sum0))); // R2
  AST_MISS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    out_miss |-> (!out_valid && out_addr == '0 && out_part == 2'd0)); // R6
  AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (out_valid ^ out_miss)); // R7
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && !out_miss)); // R7
  AST_RESERVED_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_sel == 3'd7) |=> ($stable(st0) && $stable(sz0) && $stable(st3) && $stable(p3_en))); // R8
  AST_ZERO_LEN0: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sz0 == '0) |=> !(out_valid && out_part == 2'd0)); // R10
endmodule

bind addr_window_xlat addr_window_xlat_chk #(.AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_sel(cfg_sel),
  .req_valid(req_valid), .req_addr(req_addr),
  .out_valid(out_valid), .out_miss(out_miss), .out_part(out_part), .out_addr(out_addr),
  .st0(st0), .sz0(sz0), .st3(st3), .p3_en(p3_en)
);

// File: tb/test_addr_window_xlat.sv
`timescale 1ns/1ps
module test_addr_window_xlat;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_valid = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [31:0] cfg_data = '0;
  logic req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic out_valid, out_miss;
  logic [1:0] out_part;
  logic [31:0] out_addr;

  int checks = 0, fails = 0;
  logic [31:0] mst [4];
  logic [31:0] msz [3];
  bit m_en3;

  always #2.5 clk = ~clk;

  addr_window_xlat #(.AW(32)) i_addr_window_xlat (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .req_valid(req_valid), .req_addr(req_addr),
    .out_valid(out_valid), .out_miss(out_miss), .out_part(out_part), .out_addr(out_addr));

  function automatic longint base_of(int i);
    longint b = 0;
    for (int k = 0; k < i; k++) b += longint'(msz[k]);
    return b;
  endfunction

  function automatic void model(input logic [31:0] v, output bit ev, output bit em,
                                output logic [1:0] ep, output logic [31:0] ea);
    longint b, e;
    ev = 0; em = 1; ep = 0; ea = 0;
    for (int i = 0; i < 4; i++) begin
      b = base_of(i);
      if (i < 3) e = b + longint'(msz[i]);
      else e = m_en3 ? 64'h1_0000_0000 : b;
      if (ev == 0 && longint'(v) >= b && longint'(v) < e) begin
        ev = 1; em = 0; ep = 2'(i);
        ea = mst[i] + (v - 32'(b));
      end
    end
  endfunction

  function automatic void model_write(input logic [2:0] s, input logic [31:0] d);
    case (s)
      3'd0: mst[0] = d; 3'd1: msz[0] = d;
      3'd2: mst[1] = d; 3'd3: msz[1] = d;
      3'd4: mst[2] = d; 3'd5: msz[2] = d;
      3'd6: begin mst[3] = d; m_en3 = 1; end
      default: ;
    endcase
  endfunction

  task automatic compare(input string tag, input bit ev, input bit em,
                         input logic [1:0] ep, input logic [31:0] ea);
    checks++;
    if (out_valid !== ev || out_miss !== em || out_part !== ep || out_addr !== ea) begin
      fails++;
      $display("FAIL %s: got v=%0b m=%0b p=%0d a=%h, want v=%0b m=%0b p=%0d a=%h",
               tag, out_valid, out_miss, out_part, out_addr, ev, em, ep, ea);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_valid = 1; cfg_sel = s; cfg_data = d;
    @(posedge clk); #1;
    cfg_valid = 0;
    model_write(s, d);
  endtask

  task automatic rq(input string tag, input logic [31:0] v);
    bit ev, em; logic [1:0] ep; logic [31:0] ea;
    @(negedge clk);
    req_valid = 1; req_addr = v;
    model(v, ev, em, ep, ea);
    @(posedge clk); #1;
    req_valid = 0;
    compare(tag, ev, em, ep, ea);
  endtask

  task automatic layout(input logic [31:0] s0, z0, s1, z1, s2, z2, s3);
    wr(3'd0, s0); wr(3'd1, z0); wr(3'd2, s1); wr(3'd3, z1);
    wr(3'd4, s2); wr(3'd5, z2); wr(3'd6, s3);
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog: run did not end, want completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) mst[i] = 0;
    for (int i = 0; i < 3; i++) msz[i] = 0;
    m_en3 = 0;
    void'($urandom(32'd1234));
    #1; compare("R1 in reset", 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    rq("R1 unconfigured addr 0", 32'h0);
    rq("R1 unconfigured top", 32'hFFFF_FFFF);

    layout(32'h1000_0000, 32'h100, 32'h2000_0000, 32'h40, 32'h3000_0000, 32'h200, 32'h4000_0000);
    rq("R2 first", 32'h0);
    rq("R2 last", 32'hFF);
    rq("R3 first", 32'h100);
    rq("R3 last", 32'h13F);
    rq("R4 first", 32'h140);
    rq("R4 last", 32'h33F);
    rq("R5 first", 32'h340);
    rq("R5 top", 32'hFFFF_FFFF);
    @(posedge clk); #1; compare("R7 idle", 0, 0, 0, 0);

    wr(3'd3, 32'h0);
    rq("R10 zero length1 boundary", 32'h100);
    rq("R10 zero length1 next", 32'h2FF);
    wr(3'd7, 32'hDEAD_BEEF);
    rq("R8 reserved select", 32'h10);

    wr(3'd0, 32'hFFFF_FFF0);
    rq("R9 wrap", 32'h20);

    wr(3'd1, 32'hFFFF_0000); wr(3'd5, 32'h0002_0000);
    rq("R9 boundary beyond top", 32'hFFFF_FFFF);
    rq("R9 part2 near top", 32'hFFFF_0000);

    // R11: write and request in one cycle
    @(negedge clk);
    begin
      bit ev, em; logic [1:0] ep; logic [31:0] ea;
      cfg_valid = 1; cfg_sel = 3'd0; cfg_data = 32'h5555_0000;
      req_valid = 1; req_addr = 32'h4;
      model(32'h4, ev, em, ep, ea);
      @(posedge clk); #1;
      cfg_valid = 0; req_valid = 0;
      model_write(3'd0, 32'h5555_0000);
      compare("R11 same cycle old config", ev, em, ep, ea);
    end
    rq("R11 next cycle new config", 32'h4);

    // reset clears: R1
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < 4; i++) mst[i] = 0;
    for (int i = 0; i < 3; i++) msz[i] = 0;
    m_en3 = 0;
    rq("R1 after re-reset", 32'h4);

    for (int n = 0; n < 60; n++) begin
      logic [31:0] zz [3];
      for (int k = 0; k < 3; k++) zz[k] = ($urandom % 5 == 0) ? 32'h0 : ($urandom % 32'h10_0000);
      if ($urandom % 3 == 0) begin
        wr(3'd0, $urandom); wr(3'd1, zz[0]); wr(3'd2, $urandom); wr(3'd3, zz[1]);
        wr(3'd4, $urandom); wr(3'd5, zz[2]);
      end else begin
        layout($urandom, zz[0], $urandom, zz[1], $urandom, zz[2], $urandom);
      end
      for (int j = 0; j < 8; j++) begin
        int p = $urandom % 4;
        longint b = base_of(p);
        longint a = b + longint'($urandom % 3) - 1;
        if (a < 0) a = 0;
        if (j == 7) a = longint'($urandom);
        case (p)
          0: rq("R2 random", 32'(a));
          1: rq("R3 random", 32'(a));
          2: rq("R4 random", 32'(a));
          default: rq("R5 random", 32'(a));
        endcase
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule